// File: doc/BRIEF.md
# Host Command Checksum Handshake Engine

This block sits behind a byte-wide serial receiver and transmitter on a device that relays host commands onto a slow line. The host opens a command with a header byte that has bit 2 set. Header bit 0 selects the frame length. A standard frame is the header plus one code byte. An extended frame is five bytes. When the last byte arrives, the engine replies with the modulo-256 sum of the whole frame. It then waits for the host to confirm with a zero byte, or to give up and resend.

After a zero confirmation, the engine pulses a start strobe for the line transmitter and holds the captured frame bytes on a wide output. It then waits for the transmitter's completion input and answers with the ready code 0x55. Two single-byte commands control a ring output. These commands are confirmed by the same echo and zero-byte handshake. A confirmed ring command changes the output and sends the ready code at once, without starting the line.

Top module: `hostcmd_sum_engine`

## Requirements
- R1: After reset `ring_en` is 1, and `tx_valid` and `xmit_go` are 0.
- R2: A reply byte (`tx_valid` high for one cycle) is only ever produced in the cycle after an accepted host byte or a completion. While idle, host bytes with bit 2 clear, other than 0xEB and 0xDB, produce no reply and no strobe.
- R3: A header with bit 2 set and bit 0 clear starts a two-byte frame. The cycle after the second byte is received, the reply is (header + code) mod 256.
- R4: A header with bits 2 and 0 set starts a five-byte frame. No reply is given for the first four bytes. The cycle after the fifth byte, the reply is the mod-256 sum of all five bytes.
- R5: A 0x00 received while awaiting confirmation of a frame raises `xmit_go` for exactly one cycle, in the next cycle. `frame_out` then holds the header in bits 7:0 and each later byte i in bits 8i+7:8i, with unused bytes 0.
- R6: Any non-zero byte received while awaiting confirmation is handled as if the engine were idle. A header restarts the frame with a fresh sum. Any other byte returns the engine to idle, so a later 0x00 starts nothing.
- R7: From the `xmit_go` pulse until completion, host bytes produce no reply and no second strobe.
- R8: When `xmit_done` is high in the awaiting-completion state, 0x55 is sent in the next cycle. When `xmit_done` is high at any other time, it has no effect.
- R9: Byte 0xDB (ring off) or 0xEB (ring on) is echoed in the next cycle. A following 0x00 updates `ring_en` and sends 0x55 in the next cycle, and `xmit_go` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Host byte present this cycle |
| rx_byte | input | 8 | Host byte |
| xmit_done | input | 1 | Line transmission finished |
| tx_valid | output | 1 | Reply byte valid (one cycle) |
| tx_byte | output | 8 | Reply byte |
| xmit_go | output | 1 | One-cycle start strobe for the line |
| frame_out | output | 40 | Captured frame, header in the low byte |
| ring_en | output | 1 | Ring output enable |

## Verification
A wrong internal state shows up at the reply port within one cycle of the next host byte. A miscounted frame length gives the checksum too early, which is an unexpected reply byte, or too late, which is a missing one. A stale accumulator gives a wrong sum. Falling into the wrong wait state shows up as a strobe with no confirmation, a ready code with no completion, or silence where a reply is due. All of these are visible by the cycle after the offending input. The resend, early-abort and ring paths are each driven so that every wait state is left by every exit it has.

// File: rtl/hostcmd_sum_engine.sv
module hostcmd_sum_engine #(
  parameter int BYTE_W  = 8,
  parameter int EXT_LEN = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rx_valid,
  input  logic [BYTE_W-1:0]         rx_byte,
  input  logic                      xmit_done,
  output logic                      tx_valid,
  output logic [BYTE_W-1:0]         tx_byte,
  output logic                      xmit_go,
  output logic [EXT_LEN*BYTE_W-1:0] frame_out,
  output logic                      ring_en
);
  localparam int CW = $clog2(EXT_LEN);
  localparam logic [BYTE_W-1:0] ACK_CODE   = '0;
  localparam logic [BYTE_W-1:0] READY_CODE = BYTE_W'(8'h55);
  localparam logic [BYTE_W-1:0] RING_ON    = BYTE_W'(8'hEB);
  localparam logic [BYTE_W-1:0] RING_OFF   = BYTE_W'(8'hDB);
  localparam logic [CW-1:0] LAST_EXT = CW'(EXT_LEN - 2);

  typedef enum logic [1:0] {S_IDLE, S_FRAME, S_ACK, S_LINE} state_t;

  state_t                           state;
  logic [EXT_LEN-1:0][BYTE_W-1:0]   frame;
  logic [BYTE_W-1:0]                acc;
  logic [CW-1:0]                    cnt;
  logic                             ring_cmd, ring_val;

  wire is_ack   = rx_valid && rx_byte == ACK_CODE;
  wire is_ring  = rx_valid && (rx_byte == RING_ON || rx_byte == RING_OFF);
  wire is_hdr   = rx_valid && rx_byte[2];
  wire [CW-1:0] last_idx = frame[0][0] ? LAST_EXT : '0;
  wire [BYTE_W-1:0] sum_next = acc + rx_byte;

  assign frame_out = frame;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      frame    <= '0;
      acc      <= '0;
      cnt      <= '0;
      ring_cmd <= 1'b0;
      ring_val <= 1'b1;
      ring_en  <= 1'b1;
      tx_valid <= 1'b0;
      tx_byte  <= '0;
      xmit_go  <= 1'b0;
    end else begin
      tx_valid <= 1'b0;
      xmit_go  <= 1'b0;
      case (state)
        S_IDLE, S_ACK: begin
          if (state == S_ACK && is_ack) begin
            if (ring_cmd) begin
              ring_en  <= ring_val;
              tx_valid <= 1'b1;
              tx_byte  <= READY_CODE;
              state    <= S_IDLE;
            end else begin
              xmit_go <= 1'b1;
              state   <= S_LINE;
            end
          end else if (is_ring) begin
            ring_cmd <= 1'b1;
            ring_val <= (rx_byte == RING_ON);
            tx_valid <= 1'b1;
            tx_byte  <= rx_byte;
            state    <= S_ACK;
          end else if (is_hdr) begin
            ring_cmd <= 1'b0;
            frame    <= '0;
            frame[0] <= rx_byte;
            acc      <= rx_byte;
            cnt      <= '0;
            state    <= S_FRAME;
          end else if (rx_valid) begin
            state <= S_IDLE;
          end
        end
        S_FRAME: begin
          if (rx_valid) begin
            frame[CW'(cnt + 1'b1)] <= rx_byte;
            acc <= sum_next;
            cnt <= cnt + 1'b1;
            if (cnt == last_idx) begin
              tx_valid <= 1'b1;
              tx_byte  <= sum_next;
              state    <= S_ACK;
            end
          end
        end
        S_LINE: begin
          if (xmit_done) begin
            tx_valid <= 1'b1;
            tx_byte  <= READY_CODE;
            state    <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module hostcmd_sum_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_valid,
  input logic [7:0] rx_byte,
  input logic       xmit_done,
  input logic       tx_valid,
  input logic [7:0] tx_byte,
  input logic       xmit_go,
  input logic       ring_en
);
  assert_go_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xmit_go |=> !xmit_go);

  assert_go_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xmit_go |-> $past(rx_valid && rx_byte == 8'h00));

  assert_reply_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(rx_valid || xmit_done));

  assert_go_no_reply_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xmit_go |-> !tx_valid);

  assert_ring_on_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_en != $past(ring_en)) |-> $past(rx_valid && rx_byte == 8'h00));

  assert_ring_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_en != $past(ring_en)) |-> (tx_valid && tx_byte == 8'h55 && !xmit_go));
endmodule

bind hostcmd_sum_engine hostcmd_sum_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
  .xmit_done(xmit_done), .tx_valid(tx_valid), .tx_byte(tx_byte),
  .xmit_go(xmit_go), .ring_en(ring_en)
);

// File: tb/hostcmd_sum_engine_tb.sv
module hostcmd_sum_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        xmit_done = 1'b0;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic        xmit_go;
  logic [39:0] frame_out;
  logic        ring_en;

  int checks = 0;
  int errors = 0;
  int go_cnt = 0;
  bit finished = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  hostcmd_sum_engine u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .xmit_done(xmit_done), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .xmit_go(xmit_go), .frame_out(frame_out), .ring_en(ring_en)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (xmit_go) go_cnt++;
      if (tx_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R2/R7 unexpected reply: actual %02h expected none", tx_byte);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (tx_byte !== e) begin
            errors++;
            $display("FAIL %s reply: actual %02h expected %02h", t, tx_byte, e);
          end
        end
      end
    end
  end

  task automatic expect_tx(input logic [7:0] b, input string t);
    exp_q.push_back(b);
    tag_q.push_back(t);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    xmit_done = 1'b1;
    @(negedge clk);
    xmit_done = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string t, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", t, act, exp);
    end
  endtask

  task automatic drained(input string t);
    check({t, " pending replies"}, 64'(exp_q.size()), 64'd0);
  endtask

  initial begin
    idle(3);
    // R1 reset state
    check("R1 ring_en", 64'(ring_en), 64'd1);
    check("R1 tx_valid", 64'(tx_valid), 64'd0);
    check("R1 xmit_go", 64'(xmit_go), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R2 bytes without bit 2 are ignored while idle
    send(8'h03); send(8'h00); send(8'hC3); send(8'h00);
    idle(3);
    check("R2 no strobe", 64'(go_cnt), 64'd0);
    // R8 completion while idle ignored
    done_pulse();
    idle(3);

    // R3 standard frame
    expect_tx(8'h6A, "R3");
    send(8'h04); send(8'h66);
    idle(2);
    drained("R3");
    send(8'h00);
    idle(2);
    check("R5 strobe count", 64'(go_cnt), 64'd1);
    check("R5 frame", 64'(frame_out), 64'h00_0000_6604);
    // R7 bytes during line time ignored
    send(8'h04); send(8'h66); send(8'h00);
    idle(2);
    check("R7 strobe count", 64'(go_cnt), 64'd1);
    expect_tx(8'h55, "R8");
    done_pulse();
    idle(2);
    drained("R8");

    // R6 resend after a wrong checksum
    expect_tx(8'hEA, "R6");
    send(8'h86); send(8'h64);
    expect_tx(8'hEA, "R6");
    send(8'h86); send(8'h64);
    idle(2);
    check("R6 no strobe on resend", 64'(go_cnt), 64'd1);
    send(8'h00);
    idle(2);
    check("R5 strobe after resend", 64'(go_cnt), 64'd2);
    expect_tx(8'h55, "R8");
    done_pulse();
    idle(2);

    // R4 extended frame
    send(8'h07); send(8'hA7); send(8'h03); send(8'hFF);
    idle(3);
    drained("R4 early");
    expect_tx(8'h05, "R4");
    send(8'h55);
    idle(2);
    drained("R4");
    send(8'h00);
    idle(2);
    check("R5 extended strobe", 64'(go_cnt), 64'd3);
    check("R5 extended frame", 64'(frame_out), 64'h55_FF03_A707);
    expect_tx(8'h55, "R8");
    done_pulse();
    idle(2);

    // R9 ring off then on
    expect_tx(8'hDB, "R9");
    send(8'hDB);
    expect_tx(8'h55, "R9");
    send(8'h00);
    idle(2);
    check("R9 ring off", 64'(ring_en), 64'd0);
    check("R9 no strobe", 64'(go_cnt), 64'd3);
    expect_tx(8'hEB, "R9");
    send(8'hEB);
    expect_tx(8'h55, "R9");
    send(8'h00);
    idle(2);
    check("R9 ring on", 64'(ring_en), 64'd1);

    // R6 abort by a non-header byte
    expect_tx(8'h6A, "R6");
    send(8'h04); send(8'h66);
    send(8'h13); send(8'h00);
    idle(3);
    check("R6 abort no strobe", 64'(go_cnt), 64'd3);

    // R3 dim header with function code
    expect_tx(8'h1B, "R3");
    send(8'hB6); send(8'h65);
    send(8'h00);
    idle(2);
    check("R5 dim strobe", 64'(go_cnt), 64'd4);
    check("R5 dim frame", 64'(frame_out), 64'h00_0000_65B6);
    expect_tx(8'h55, "R8");
    done_pulse();
    idle(3);
    drained("final");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule